// File: doc/BRIEF.md
# Three-Wire Dual-Loop Synthesizer Configuration Port

This block is the serial control port of a frequency synthesizer that has two phase-locked loops. A host drives three wires: a serial clock, a data line and a load strobe. While the strobe is low, each rising edge of the serial clock moves one data bit into a 23-bit shift register. Words are sent most significant bit first, so the two bits sent last act as the routing code. When the strobe goes high, the controller copies the register contents into one of four holding latches. Each loop has a reference-divider latch and a main/swallow-divider latch.

The latched fields leave the block as parallel outputs:
- for each loop's reference side: a 14-bit reference ratio, a charge-pump high-current select and a 2-bit test-monitor select;
- for each loop's divider side: an 11-bit main count, a 7-bit swallow count, a monitor-output select, a prescaler modulus select and a detector polarity select.

A word that asks for a reference ratio or a main count below 3 is not accepted. That latch keeps its previous contents and a sticky error output goes high.

The serial wires are assumed to be already synchronous to the system clock `clk`. Edges of the serial clock are found by comparing it with its value one cycle earlier.

A three-state controller sequences each transfer:
- `ST_SHIFT` accepts bits. It moves to `ST_XFER` when the strobe is seen high.
- `ST_XFER` lasts one cycle and writes the selected latch. It moves to `ST_HOLD` if the strobe is still high, or back to `ST_SHIFT` if the strobe is already low.
- `ST_HOLD` waits for the strobe to fall and then returns to `ST_SHIFT`.

Top module: `synth_cfg_port`

## Requirements
- R1: In `ST_SHIFT` with the strobe low, each rising edge of `ser_clk` shifts `ser_data` into the register. Word position 1 is the last bit shifted and position 23 is the first.
- R2: Position 1 (loop bit) and position 2 (kind bit) choose the destination. Kind 0 with loop 0 selects the loop-0 reference latch. Kind 0 with loop 1 selects the loop-1 reference latch. Kind 1 with loop 0 selects the loop-0 divider latch. Kind 1 with loop 1 selects the loop-1 divider latch.
- R3: Reference word layout:
  - position 3 goes to `tsel[0]` and position 4 to `tsel[1]`;
  - positions 5 to 18 form the reference ratio, with position 5 as the LSB;
  - position 19 goes to `cp_hi`;
  - positions 20 to 23 have no effect.
- R4: Divider word layout:
  - position 3 goes to `mon_sel`, position 4 to `mod_sel` and position 5 to `pol`;
  - positions 6 to 12 form the swallow count, with position 6 as the LSB;
  - positions 13 to 23 form the main count, with position 13 as the LSB.
- R5: One high pulse of the strobe writes the selected latch exactly once. The other three latches keep their values.
- R6: Rising edges of `ser_clk` while the strobe is high, or outside `ST_SHIFT`, leave the shift register unchanged.
- R7: A reference ratio or main count below 3 is not latched, and the target latch keeps its old contents. `cfg_err` then goes high and stays high until reset. The swallow count accepts any value.
- R8: After reset, both reference ratios and both main counts are 3, both swallow counts are 0, all select bits are 0 and `cfg_err` is 0.
- R9: A transfer uses the last 23 bits shifted. Bits shifted before those are lost.
- R10: The `clk` edge that first samples the strobe high enters `ST_XFER`. The latch outputs change at the next `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, synchronous level |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe |
| l0_ref_div | output | 14 | Loop 0 reference ratio |
| l0_cp_hi | output | 1 | Loop 0 charge-pump high-current select |
| l0_tsel | output | 2 | Loop 0 test-monitor select |
| l0_main_div | output | 11 | Loop 0 main count |
| l0_swallow | output | 7 | Loop 0 swallow count |
| l0_mon_sel | output | 1 | Loop 0 monitor-output select |
| l0_mod_sel | output | 1 | Loop 0 prescaler modulus select |
| l0_pol | output | 1 | Loop 0 detector polarity |
| l1_ref_div | output | 14 | Loop 1 reference ratio |
| l1_cp_hi | output | 1 | Loop 1 charge-pump high-current select |
| l1_tsel | output | 2 | Loop 1 test-monitor select |
| l1_main_div | output | 11 | Loop 1 main count |
| l1_swallow | output | 7 | Loop 1 swallow count |
| l1_mon_sel | output | 1 | Loop 1 monitor-output select |
| l1_mod_sel | output | 1 | Loop 1 prescaler modulus select |
| l1_pol | output | 1 | Loop 1 detector polarity |
| cfg_err | output | 1 | Sticky error flag for prohibited ratios |

## Verification
The hardest case to reach from the ports is proving that serial clock edges during a strobe-high pulse are discarded. The shift register cannot be seen directly, and a discarded edge changes nothing visible on its own. The bench first loads a valid word. It then toggles `ser_clk` with the data line held at one while the strobe is high, drops the strobe, and raises it again without shifting anything. If any discarded edge had been taken, the low bits would read as ones. That would reroute the replayed word to the loop-1 divider latch and visibly change its fields. The bench checks the same way that bits shifted before the last 23 are lost: it sends a leading run of ones that would corrupt the routing bits if it were kept.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,
        ST_XFER  = 2'd1,
        ST_HOLD  = 2'd2
    } xfer_state_e;

    // Word positions (0-based register index = position - 1)
    localparam int POS_LOOP  = 0;
    localparam int POS_KIND  = 1;
    localparam int POS_FLAG0 = 2;
    localparam int POS_FLAG1 = 3;
    localparam int POS_FLAG2 = 4;
    localparam int POS_RATIO = 4;
    localparam int POS_SWAL  = 5;

    localparam int NUM_LOOPS = 2;

endpackage

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int WORD_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              shift_allow,
    output logic [WORD_W-1:0] word
);

    logic sclk_q;
    logic sclk_rise;

    assign sclk_rise = ser_clk && !sclk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= ser_clk;
        end
    end

    // Newest bit enters at index 0; oldest falls off the top (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else if (sclk_rise && shift_allow) begin
            word <= {word[WORD_W-2:0], ser_data};
        end
    end

    // R6: blocked edges leave the register alone
    p_blocked_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_allow |=> $stable(word));

    // R1: an accepted edge places the data bit at position 1
    p_bit_enters_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && shift_allow) |=> (word[0] == $past(ser_data)));

endmodule

// File: rtl/cfg_fsm.sv
module cfg_fsm
    import synth_cfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ser_le,
    output logic shift_allow,
    output logic commit
);

    xfer_state_e state_q;
    xfer_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SHIFT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHIFT: if (ser_le) state_d = ST_XFER;
            ST_XFER:  state_d = ser_le ? ST_HOLD : ST_SHIFT;
            ST_HOLD:  if (!ser_le) state_d = ST_SHIFT;
            default:  state_d = ST_SHIFT;
        endcase
    end

    always_comb begin
        shift_allow = 1'b0;
        commit      = 1'b0;
        unique case (state_q)
            ST_SHIFT: shift_allow = !ser_le;
            ST_XFER:  commit      = 1'b1;
            ST_HOLD:  ;
            default:  ;
        endcase
    end

    // R10: strobe seen high in the shift state leads to a write next cycle
    p_xfer_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && ser_le) |=> commit);

    // R5: a write never lasts two cycles
    p_single_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

    // R5: no second write while the strobe stays high
    p_hold_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ser_le) && ser_le && !commit) |-> !shift_allow);

endmodule

// File: rtl/cfg_ref_latch.sv
module cfg_ref_latch #(
    parameter int REF_W     = 14,
    parameter int MIN_RATIO = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [REF_W-1:0] in_ratio,
    input  logic [1:0]       in_tsel,
    input  logic             in_cp,
    output logic [REF_W-1:0] ratio,
    output logic [1:0]       tsel,
    output logic             cp_hi,
    output logic             reject
);

    localparam logic [REF_W-1:0] MIN_R = REF_W'(MIN_RATIO);

    logic ok;

    assign ok     = (in_ratio >= MIN_R);
    assign reject = load && !ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio <= MIN_R;
            tsel  <= 2'b00;
            cp_hi <= 1'b0;
        end else if (load && ok) begin
            ratio <= in_ratio;
            tsel  <= in_tsel;
            cp_hi <= in_cp;
        end
    end

    // R7: a prohibited ratio is never held
    p_ref_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ratio >= MIN_R);

    // R5: contents move only on a write
    p_ref_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({ratio, tsel, cp_hi}));

    // R3: an accepted write takes the presented ratio
    p_ref_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_ratio >= MIN_R) |=> (ratio == $past(in_ratio)));

endmodule

// File: rtl/cfg_div_latch.sv
module cfg_div_latch #(
    parameter int MAIN_W    = 11,
    parameter int SWAL_W    = 7,
    parameter int MIN_RATIO = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MAIN_W-1:0] in_main,
    input  logic [SWAL_W-1:0] in_swal,
    input  logic              in_mon,
    input  logic              in_mod,
    input  logic              in_pol,
    output logic [MAIN_W-1:0] main_div,
    output logic [SWAL_W-1:0] swallow,
    output logic              mon_sel,
    output logic              mod_sel,
    output logic              pol,
    output logic              reject
);

    localparam logic [MAIN_W-1:0] MIN_N = MAIN_W'(MIN_RATIO);

    logic ok;

    assign ok     = (in_main >= MIN_N);
    assign reject = load && !ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_div <= MIN_N;
            swallow  <= '0;
            mon_sel  <= 1'b0;
            mod_sel  <= 1'b0;
            pol      <= 1'b0;
        end else if (load && ok) begin
            main_div <= in_main;
            swallow  <= in_swal;
            mon_sel  <= in_mon;
            mod_sel  <= in_mod;
            pol      <= in_pol;
        end
    end

    // R7: a prohibited main count is never held
    p_div_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
        main_div >= MIN_N);

    // R5: contents move only on a write
    p_div_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable({main_div, swallow, mon_sel, mod_sel, pol}));

    // R4: an accepted write takes the presented swallow count
    p_div_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && in_main >= MIN_N) |=> (swallow == $past(in_swal)));

endmodule

// File: rtl/synth_cfg_port.sv
module synth_cfg_port
    import synth_cfg_pkg::*;
#(
    parameter int REF_W     = 14,
    parameter int MAIN_W    = 11,
    parameter int SWAL_W    = 7,
    parameter int MIN_RATIO = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic              ser_le,
    output logic [REF_W-1:0]  l0_ref_div,
    output logic              l0_cp_hi,
    output logic [1:0]        l0_tsel,
    output logic [MAIN_W-1:0] l0_main_div,
    output logic [SWAL_W-1:0] l0_swallow,
    output logic              l0_mon_sel,
    output logic              l0_mod_sel,
    output logic              l0_pol,
    output logic [REF_W-1:0]  l1_ref_div,
    output logic              l1_cp_hi,
    output logic [1:0]        l1_tsel,
    output logic [MAIN_W-1:0] l1_main_div,
    output logic [SWAL_W-1:0] l1_swallow,
    output logic              l1_mon_sel,
    output logic              l1_mod_sel,
    output logic              l1_pol,
    output logic              cfg_err
);

    localparam int POS_CP   = POS_RATIO + REF_W;
    localparam int POS_MAIN = POS_SWAL + SWAL_W;
    localparam int DIV_LEN  = POS_MAIN + MAIN_W;
    localparam int REF_LEN  = POS_CP + 1;
    localparam int WORD_W   = (DIV_LEN > REF_LEN) ? DIV_LEN : REF_LEN;

    logic [WORD_W-1:0] sr_word;
    logic              shift_allow;
    logic              commit;

    logic [REF_W-1:0]  ref_div_a [NUM_LOOPS];
    logic              cp_a      [NUM_LOOPS];
    logic [1:0]        tsel_a    [NUM_LOOPS];
    logic [MAIN_W-1:0] main_a    [NUM_LOOPS];
    logic [SWAL_W-1:0] swal_a    [NUM_LOOPS];
    logic              mon_a     [NUM_LOOPS];
    logic              mod_a     [NUM_LOOPS];
    logic              pol_a     [NUM_LOOPS];
    logic [NUM_LOOPS-1:0] ref_ld, div_ld, ref_rej, div_rej;

    cfg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_le      (ser_le),
        .shift_allow (shift_allow),
        .commit      (commit)
    );

    cfg_shift #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk     (ser_clk),
        .ser_data    (ser_data),
        .shift_allow (shift_allow),
        .word        (sr_word)
    );

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        assign ref_ld[g] = commit && !sr_word[POS_KIND] && (sr_word[POS_LOOP] == g[0]);
        assign div_ld[g] = commit &&  sr_word[POS_KIND] && (sr_word[POS_LOOP] == g[0]);

        cfg_ref_latch #(.REF_W(REF_W), .MIN_RATIO(MIN_RATIO)) u_ref (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ref_ld[g]),
            .in_ratio (sr_word[POS_RATIO +: REF_W]),
            .in_tsel  ({sr_word[POS_FLAG1], sr_word[POS_FLAG0]}),
            .in_cp    (sr_word[POS_CP]),
            .ratio    (ref_div_a[g]),
            .tsel     (tsel_a[g]),
            .cp_hi    (cp_a[g]),
            .reject   (ref_rej[g])
        );

        cfg_div_latch #(.MAIN_W(MAIN_W), .SWAL_W(SWAL_W), .MIN_RATIO(MIN_RATIO)) u_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (div_ld[g]),
            .in_main  (sr_word[POS_MAIN +: MAIN_W]),
            .in_swal  (sr_word[POS_SWAL +: SWAL_W]),
            .in_mon   (sr_word[POS_FLAG0]),
            .in_mod   (sr_word[POS_FLAG1]),
            .in_pol   (sr_word[POS_FLAG2]),
            .main_div (main_a[g]),
            .swallow  (swal_a[g]),
            .mon_sel  (mon_a[g]),
            .mod_sel  (mod_a[g]),
            .pol      (pol_a[g]),
            .reject   (div_rej[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else if ((|ref_rej) || (|div_rej)) begin
            cfg_err <= 1'b1;
        end
    end

    assign l0_ref_div  = ref_div_a[0];
    assign l0_cp_hi    = cp_a[0];
    assign l0_tsel     = tsel_a[0];
    assign l0_main_div = main_a[0];
    assign l0_swallow  = swal_a[0];
    assign l0_mon_sel  = mon_a[0];
    assign l0_mod_sel  = mod_a[0];
    assign l0_pol      = pol_a[0];
    assign l1_ref_div  = ref_div_a[1];
    assign l1_cp_hi    = cp_a[1];
    assign l1_tsel     = tsel_a[1];
    assign l1_main_div = main_a[1];
    assign l1_swallow  = swal_a[1];
    assign l1_mon_sel  = mon_a[1];
    assign l1_mod_sel  = mod_a[1];
    assign l1_pol      = pol_a[1];

    // R2: a write reaches at most one latch
    p_one_dest_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ref_ld, div_ld}));

    // R7: the error flag never clears without reset
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R6: the word is frozen while a write is in progress
    p_word_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> $stable(sr_word));

endmodule

// File: tb/tb_synth_cfg_port.sv
module tb_synth_cfg_port;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [13:0] l0_ref_div, l1_ref_div;
    logic [10:0] l0_main_div, l1_main_div;
    logic [6:0]  l0_swallow, l1_swallow;
    logic [1:0]  l0_tsel, l1_tsel;
    logic l0_cp_hi, l0_mon_sel, l0_mod_sel, l0_pol;
    logic l1_cp_hi, l1_mon_sel, l1_mod_sel, l1_pol;
    logic cfg_err;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    logic [13:0] e_ref [2];
    logic [1:0]  e_ts  [2];
    logic        e_cp  [2];
    logic [10:0] e_n   [2];
    logic [6:0]  e_a   [2];
    logic        e_mon [2];
    logic        e_mod [2];
    logic        e_pol [2];
    logic        e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    synth_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .l0_ref_div(l0_ref_div), .l0_cp_hi(l0_cp_hi), .l0_tsel(l0_tsel),
        .l0_main_div(l0_main_div), .l0_swallow(l0_swallow), .l0_mon_sel(l0_mon_sel),
        .l0_mod_sel(l0_mod_sel), .l0_pol(l0_pol),
        .l1_ref_div(l1_ref_div), .l1_cp_hi(l1_cp_hi), .l1_tsel(l1_tsel),
        .l1_main_div(l1_main_div), .l1_swallow(l1_swallow), .l1_mon_sel(l1_mon_sel),
        .l1_mod_sel(l1_mod_sel), .l1_pol(l1_pol),
        .cfg_err(cfg_err)
    );

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 2; i++) begin
            e_ref[i] = 14'd3; e_ts[i] = 2'b00; e_cp[i] = 1'b0;
            e_n[i] = 11'd3; e_a[i] = '0; e_mon[i] = 1'b0; e_mod[i] = 1'b0; e_pol[i] = 1'b0;
        end
        e_err = 1'b0;
    endtask

    // Expected effect of one transfer, from R2/R3/R4/R7
    task automatic model_apply(logic [22:0] w);
        int lp;
        lp = int'(w[0]);
        if (!w[1]) begin
            if (w[17:4] < 14'd3) e_err = 1'b1;
            else begin
                e_ref[lp] = w[17:4]; e_ts[lp] = {w[3], w[2]}; e_cp[lp] = w[18];
            end
        end else begin
            if (w[22:12] < 11'd3) e_err = 1'b1;
            else begin
                e_n[lp] = w[22:12]; e_a[lp] = w[11:5];
                e_mon[lp] = w[2]; e_mod[lp] = w[3]; e_pol[lp] = w[4];
            end
        end
    endtask

    function automatic logic [22:0] mk_ref(logic lp, logic [1:0] t, logic [13:0] r,
                                           logic cs, logic [3:0] dc);
        return {dc, cs, r, t, 1'b0, lp};
    endfunction

    function automatic logic [22:0] mk_div(logic lp, logic mon, logic md, logic pl,
                                           logic [6:0] a, logic [10:0] n);
        return {n, a, pl, md, mon, 1'b1, lp};
    endfunction

    task automatic shift_bits(logic [63:0] v, int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = v[i];
            tick(1);
            ser_clk = 1'b1;
            tick(2);
            ser_clk = 1'b0;
            tick(1);
        end
    endtask

    task automatic strobe();
        ser_le = 1'b1;
        tick(3);
        ser_le = 1'b0;
        tick(2);
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        @(negedge clk);
        chk(req, "l0_ref_div", 32'(l0_ref_div), 32'(e_ref[0]));
        chk(req, "l0_tsel", 32'(l0_tsel), 32'(e_ts[0]));
        chk(req, "l0_cp_hi", 32'(l0_cp_hi), 32'(e_cp[0]));
        chk(req, "l0_main_div", 32'(l0_main_div), 32'(e_n[0]));
        chk(req, "l0_swallow", 32'(l0_swallow), 32'(e_a[0]));
        chk(req, "l0_sel", {29'd0, l0_pol, l0_mod_sel, l0_mon_sel}, {29'd0, e_pol[0], e_mod[0], e_mon[0]});
        chk(req, "l1_ref_div", 32'(l1_ref_div), 32'(e_ref[1]));
        chk(req, "l1_tsel", 32'(l1_tsel), 32'(e_ts[1]));
        chk(req, "l1_cp_hi", 32'(l1_cp_hi), 32'(e_cp[1]));
        chk(req, "l1_main_div", 32'(l1_main_div), 32'(e_n[1]));
        chk(req, "l1_swallow", 32'(l1_swallow), 32'(e_a[1]));
        chk(req, "l1_sel", {29'd0, l1_pol, l1_mod_sel, l1_mon_sel}, {29'd0, e_pol[1], e_mod[1], e_mon[1]});
        chk(req, "cfg_err", 32'(cfg_err), 32'(e_err));
        tick(1);
    endtask

    task automatic send_word(logic [22:0] w, string req);
        shift_bits(64'(w), 23);
        strobe();
        model_apply(w);
        check_all(req);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [22:0] w;
        model_reset();
        tick(3);
        rst_n = 1'b1;
        tick(2);
        check_all("R8 reset");

        // R3/R2: reference words, sweeping small ratios and every power of two
        for (int r = 3; r <= 40; r++) begin
            w = mk_ref(r[0], r[2:1], 14'(r), r[1], r[6:3]);
            send_word(w, "R3 R2 ref sweep");
        end
        for (int k = 2; k < 14; k++) begin
            w = mk_ref(k[0], 2'(k), 14'(1 << k) | 14'd1, ~k[0], 4'hF);
            send_word(w, "R3 ref pow2");
        end
        send_word(mk_ref(1'b0, 2'b11, 14'h3FFF, 1'b1, 4'h0), "R3 ref max");

        // R4/R2: every swallow count, main counts spread across the range
        for (int a = 0; a < 128; a++) begin
            w = mk_div(a[0], a[1], a[2], a[3], 7'(a), 11'(3 + (a * 13) % 2045));
            send_word(w, "R4 R2 div sweep");
        end
        send_word(mk_div(1'b1, 1'b1, 1'b0, 1'b1, 7'd127, 11'd2047), "R4 div max");

        // R10 / R5: latency of the write and single write per pulse
        w = mk_div(1'b0, 1'b1, 1'b1, 1'b0, 7'd55, 11'd1234);
        shift_bits(64'(w), 23);
        ser_le = 1'b1;
        @(negedge clk);
        chk("R10 before first edge", "l0_main_div", 32'(l0_main_div), 32'(e_n[0]));
        @(negedge clk);
        chk("R10 in write cycle", "l0_main_div", 32'(l0_main_div), 32'(e_n[0]));
        @(negedge clk);
        chk("R10 after write", "l0_main_div", 32'(l0_main_div), 32'd1234);
        model_apply(w);
        tick(5);
        ser_le = 1'b0;
        tick(2);
        check_all("R5 single write");

        // R6: edges with strobe high are ignored; replay the register
        send_word(mk_ref(1'b0, 2'b01, 14'd100, 1'b0, 4'h0), "R6 setup");
        ser_le = 1'b1;
        ser_data = 1'b1;
        tick(2);
        for (int i = 0; i < 5; i++) begin
            ser_clk = 1'b1; tick(2); ser_clk = 1'b0; tick(2);
        end
        ser_le = 1'b0;
        tick(2);
        strobe();
        model_apply(mk_ref(1'b0, 2'b01, 14'd100, 1'b0, 4'h0));
        check_all("R6 clocks under strobe ignored");

        // R9: leading bits beyond 23 are lost
        w = mk_ref(1'b1, 2'b10, 14'd777, 1'b1, 4'h5);
        shift_bits({34'd0, 7'h7F, w}, 30);
        strobe();
        model_apply(w);
        check_all("R9 overflow bits dropped");

        // R7: prohibited ratios rejected, contents kept, flag sticky
        for (int v = 0; v < 3; v++) begin
            send_word(mk_ref(v[0], 2'b11, 14'(v), 1'b1, 4'h0), "R7 ref reject");
            send_word(mk_div(v[0], 1'b1, 1'b1, 1'b1, 7'd9, 11'(v)), "R7 div reject");
        end
        send_word(mk_ref(1'b0, 2'b00, 14'd3, 1'b0, 4'h0), "R7 flag stays set");

        // R8: reset again mid-run
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        model_reset();
        tick(2);
        check_all("R8 reset after use");

        report();
    end

endmodule